// File: doc/BRIEF.md
# Memory Sleep Sequencer

This block sits beside the array of a synchronous memory and takes charge of its low-power sleep state. The host raises a sleep request that may change at any time, unrelated to the memory clock. The sequencer brings that request through a synchronizer and walks the memory through a fixed number of clocks to go to sleep and a fixed number to wake. It blocks array access and forces the data outputs to high impedance for as long as the memory is not fully awake.

It also watches the host's side of the contract. Sleep must be requested only while the memory is deselected. In the wake-up window, the chip select and both address strobes must stay quiet. Any breach sets an error flag that stays set until the host pulses a clear.

All inputs and outputs are active high. An access that is pending when entry starts is dropped, not completed.

Top module: `szz_sleep_ctrl`

## Requirements
- R1: While reset is low, and after it is released with no request, `asleep_o`, `inhibit_o`, `hiz_o` and `proto_err_o` are 0 and `acc_en_o` follows `acc_req_i`. Reset acts asynchronously, even in the middle of sleep.
- R2: `sleep_req` passes through a two-flop synchronizer. Counting the rising edges after the request is set, `inhibit_o` rises after edge 3 and the block spends exactly two clocks entering. `asleep_o` rises after edge 5. Sleep is reached only by way of the entering phase.
- R3: `acc_en_o` equals `acc_req_i` only when awake, and is 0 while entering, asleep or leaving sleep. An access pending at entry is abandoned, so no array write can occur in those phases.
- R4: `hiz_o` is 1 in every phase other than awake, including the whole of the exit.
- R5: Counting the rising edges after the request is cleared, `asleep_o` falls after edge 3 and the block spends exactly two clocks exiting. `inhibit_o` and `hiz_o` fall after edge 5. The awake phase is reached only from the exit phase.
- R6: Entry always completes. If the request is withdrawn during entry, the block is asleep for at least one clock and then runs a full exit.
- R7: `select_i` high while a synchronized request is waiting in the awake phase, or during entry, is a violation. `select_i` high while asleep, or while awake with no request, is not.
- R8: Any of `select_i`, `strobe_p_i` or `strobe_c_i` high during either of the two exit clocks is a violation. Activity while asleep or while awake is not.
- R9: A violation sets `proto_err_o` one edge later. The flag holds until `err_clr_i` is high at an edge. If a clear and a violation arrive at the same edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| select_i | input | 1 | Combined chip-select, high when the memory is selected |
| strobe_p_i | input | 1 | Processor-side address strobe, active high |
| strobe_c_i | input | 1 | Controller-side address strobe, active high |
| acc_req_i | input | 1 | Array access request from the core logic |
| err_clr_i | input | 1 | Synchronous clear of the protocol-error flag |
| asleep_o | output | 1 | Memory is fully asleep |
| inhibit_o | output | 1 | Array access blocked (entering, asleep or exiting) |
| hiz_o | output | 1 | Force data outputs to high impedance |
| acc_en_o | output | 1 | Gated array access enable |
| proto_err_o | output | 1 | Sticky host protocol violation flag |

## Verification
The bench sweeps a single selection or strobe pulse across every clock of an entry and of an exit. It checks that only the clocks inside the guarded windows set the error. A design with a window one clock off would flag a harmless pulse, or miss a real breach at the window's edge.

Phase timing is checked on every clock of a full sleep cycle and of a request withdrawn during entry. An extra synchronizer stage, a short entry count, or an early return to awake shows up as a flag changing one clock early or late. A design that let the exit skip output forcing would show up the same way.

The bench also lands a clear on the same edge as a violation. A design that gives the set priority keeps the flag raised there.

// File: rtl/szz_pkg.sv
package szz_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ENTER  = 2'd1,
    ST_ASLEEP = 2'd2,
    ST_EXIT   = 2'd3
  } zz_state_t;

  // True on the last clock of a phase that lasts n clocks.
  function automatic logic phase_last(input int count, input int n);
    return (count + 1) >= n;
  endfunction

  // Counter width able to hold the longer of two phase lengths.
  function automatic int count_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/szz_sync.sv
module szz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/szz_fsm.sv
module szz_fsm
  import szz_pkg::*;
#(
  parameter int ENTER_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_s,
  output zz_state_t st_o
);

  localparam int CW = count_width(ENTER_CYCLES, EXIT_CYCLES);

  zz_state_t st;
  logic [CW-1:0] cnt;
  logic enter_last, exit_last;

  assign enter_last = phase_last(int'(cnt), ENTER_CYCLES);
  assign exit_last  = phase_last(int'(cnt), EXIT_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_AWAKE;
      cnt <= '0;
    end else begin
      case (st)
        ST_AWAKE: begin
          cnt <= '0;
          if (req_s) st <= ST_ENTER;
        end
        ST_ENTER: begin
          if (enter_last) begin
            st  <= ST_ASLEEP;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ASLEEP: begin
          cnt <= '0;
          if (!req_s) st <= ST_EXIT;
        end
        default: begin
          if (exit_last) begin
            st  <= ST_AWAKE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign st_o = st;

  assert_asleep_via_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_ASLEEP) |-> $past(st) == ST_ENTER);

  assert_entry_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st != ST_AWAKE) |-> $past(req_s));

  assert_awake_via_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_AWAKE) |-> $past(st) == ST_EXIT);

endmodule

// File: rtl/szz_guard.sv
module szz_guard
  import szz_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  zz_state_t st,
  input  logic      req_s,
  input  logic      select_i,
  input  logic      strobe_p_i,
  input  logic      strobe_c_i,
  input  logic      err_clr_i,
  output logic      err_o
);

  logic entry_breach, exit_breach, viol;
  logic err_q;

  // Selected while a request is pending or while entering.
  assign entry_breach = select_i & (((st == ST_AWAKE) & req_s) | (st == ST_ENTER));
  // Any selection or strobe inside the recovery window.
  assign exit_breach  = (st == ST_EXIT) & (select_i | strobe_p_i | strobe_c_i);
  assign viol         = entry_breach | exit_breach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (err_clr_i) err_q <= 1'b0;
    else if (viol)      err_q <= 1'b1;
  end

  assign err_o = err_q;

  assert_err_from_breach_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(viol) && !$past(err_clr_i));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_clr_i) |-> !err_q);

  assert_exit_activity_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_breach && !err_clr_i) |=> err_q);

endmodule

// File: rtl/szz_sleep_ctrl.sv
module szz_sleep_ctrl
  import szz_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTER_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic select_i,
  input  logic strobe_p_i,
  input  logic strobe_c_i,
  input  logic acc_req_i,
  input  logic err_clr_i,
  output logic asleep_o,
  output logic inhibit_o,
  output logic hiz_o,
  output logic acc_en_o,
  output logic proto_err_o
);

  logic      req_s;
  zz_state_t st;
  logic      awake;

  szz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sleep_req),
    .q    (req_s)
  );

  szz_fsm #(.ENTER_CYCLES(ENTER_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) u_fsm (
    .clk  (clk),
    .rst_n(rst_n),
    .req_s(req_s),
    .st_o (st)
  );

  szz_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .req_s     (req_s),
    .select_i  (select_i),
    .strobe_p_i(strobe_p_i),
    .strobe_c_i(strobe_c_i),
    .err_clr_i (err_clr_i),
    .err_o     (proto_err_o)
  );

  assign awake     = (st == ST_AWAKE);
  assign asleep_o  = (st == ST_ASLEEP);
  assign inhibit_o = !awake;
  assign hiz_o     = !awake;
  assign acc_en_o  = acc_req_i & awake;

  assert_no_grant_after_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_s) && !$past(awake)) |-> !acc_en_o);

  assert_hiz_through_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_o) |-> hiz_o);

endmodule

// File: tb/szz_sleep_ctrl_test.sv
module szz_sleep_ctrl_test;

  localparam int SYNC = 2;
  localparam int ENT  = 2;
  localparam int EXT  = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic select_i = 1'b0;
  logic strobe_p_i = 1'b0;
  logic strobe_c_i = 1'b0;
  logic acc_req_i = 1'b0;
  logic err_clr_i = 1'b0;
  logic asleep_o, inhibit_o, hiz_o, acc_en_o, proto_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  szz_sleep_ctrl #(.SYNC_STAGES(SYNC), .ENTER_CYCLES(ENT), .EXIT_CYCLES(EXT)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .select_i(select_i),
    .strobe_p_i(strobe_p_i), .strobe_c_i(strobe_c_i), .acc_req_i(acc_req_i),
    .err_clr_i(err_clr_i), .asleep_o(asleep_o), .inhibit_o(inhibit_o),
    .hiz_o(hiz_o), .acc_en_o(acc_en_o), .proto_err_o(proto_err_o)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Phase codes: 0 awake, 1 entering, 2 asleep, 3 exiting.
  function automatic int entry_phase(input int k);
    if (k < LAT) return 0;
    if (k < LAT + ENT) return 1;
    return 2;
  endfunction

  function automatic int exit_phase(input int k);
    if (k < LAT) return 2;
    if (k < LAT + EXT) return 3;
    return 0;
  endfunction

  task automatic check_phase(input string tag, input int ph);
    chk({tag, " asleep"}, asleep_o, ph == 2);
    chk({tag, " inhibit"}, inhibit_o, ph != 0);
    chk({tag, " R4 hiz"}, hiz_o, ph != 0);
    chk({tag, " R3 acc_en"}, acc_en_o, acc_req_i && (ph == 0));
  endtask

  task automatic clear_err;
    err_clr_i = 1'b1;
    tick();
    err_clr_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_phase("R1 in reset", 0);
    chk("R1 err in reset", proto_err_o, 1'b0);
    rst_n = 1'b1;
    tick();
    check_phase("R1 after reset", 0);

    // R3/R8: activity while awake with no request
    acc_req_i = 1'b1;
    for (int c = 0; c < 6; c++) begin
      select_i = c[0];
      strobe_p_i = c[1];
      strobe_c_i = ~c[0];
      tick();
      chk("R3 awake grant", acc_en_o, 1'b1);
    end
    select_i = 1'b0; strobe_p_i = 1'b0; strobe_c_i = 1'b0;
    tick();
    chk("R8 awake activity harmless", proto_err_o, 1'b0);

    // R2..R5: full sleep cycle, checked every clock
    sleep_req = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      check_phase("R2 entry", entry_phase(k));
    end
    sleep_req = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      tick();
      check_phase("R5 exit", exit_phase(k));
    end
    chk("R8 clean cycle no error", proto_err_o, 1'b0);

    // R7: select pulse swept across the entry
    for (int j = 0; j < 8; j++) begin
      sleep_req = 1'b1;
      for (int c = 0; c < 9; c++) begin
        select_i = (c == j);
        tick();
      end
      select_i = 1'b0;
      chk("R7 entry sweep", proto_err_o, (j >= SYNC) && (j < LAT + ENT));
      sleep_req = 1'b0;
      repeat (8) tick();
      clear_err();
      chk("R9 cleared", proto_err_o, 1'b0);
    end

    // R8: one pulse of select or a strobe swept across the exit
    for (int j = 0; j < 8; j++) begin
      sleep_req = 1'b1;
      repeat (7) tick();
      sleep_req = 1'b0;
      for (int c = 0; c < 9; c++) begin
        select_i   = (c == j) && (j % 3 == 0);
        strobe_p_i = (c == j) && (j % 3 == 1);
        strobe_c_i = (c == j) && (j % 3 == 2);
        tick();
      end
      select_i = 1'b0; strobe_p_i = 1'b0; strobe_c_i = 1'b0;
      chk("R8 exit sweep", proto_err_o, (j >= LAT) && (j < LAT + EXT));
      clear_err();
      chk("R9 cleared", proto_err_o, 1'b0);
    end

    // R9: clear on the same edge as a violation, then stickiness
    sleep_req = 1'b1;
    for (int c = 0; c < 6; c++) begin
      select_i  = (c >= 2) && (c <= 4);
      err_clr_i = (c == 3);
      tick();
      if (c == 2) chk("R9 set by breach", proto_err_o, 1'b1);
      if (c == 3) chk("R9 clear wins", proto_err_o, 1'b0);
      if (c == 4) chk("R9 set again", proto_err_o, 1'b1);
    end
    select_i = 1'b0; err_clr_i = 1'b0;
    repeat (6) tick();
    chk("R9 sticky asleep", proto_err_o, 1'b1);
    sleep_req = 1'b0;
    repeat (8) tick();
    chk("R9 sticky awake", proto_err_o, 1'b1);
    clear_err();
    chk("R9 final clear", proto_err_o, 1'b0);

    // R6: request withdrawn during entry
    sleep_req = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      tick();
      if (k <= 2)      check_phase("R6 withdraw", 0);
      else if (k <= 4) check_phase("R6 withdraw", 1);
      else if (k == 5) check_phase("R6 withdraw", 2);
      else if (k <= 7) check_phase("R6 withdraw", 3);
      else             check_phase("R6 withdraw", 0);
      if (k == 3) sleep_req = 1'b0;
    end

    // R1: asynchronous reset while asleep
    sleep_req = 1'b1;
    repeat (6) tick();
    chk("R1 asleep before reset", asleep_o, 1'b1);
    rst_n = 1'b0;
    #1;
    check_phase("R1 async reset", 0);
    sleep_req = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    check_phase("R1 after mid reset", 0);
    chk("R1 err after reset", proto_err_o, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule